// File: doc/BRIEF.md
# Interval Timer Channel Read-Back Latch

This block sits on the read side of one channel of a legacy-compatible programmable interval timer. The counting engine is outside the block. It supplies a free-running 16-bit count and an 8-bit status byte. The block accepts capture strobes that freeze the count, the status, or both. A byte-wide read port then returns any frozen status first, then the frozen count, and after that the live count.

The channel's access mode selects how the count is read. It can be read as the low byte only, the high byte only, or the low byte followed by the high byte. A mode write clears everything the channel is holding. A capture strobe that arrives while an earlier capture of the same kind is still unread is dropped. Reads are registered: the byte chosen by a read appears on `rd_data` after the clock edge that samples `rd`, and it stays there until the next read is accepted.

Top module: `tmr_rb_top`

## Requirements
- R1: After reset the channel holds no status and no count, the access mode is two-byte (low then high), the byte pointer selects the low byte, and `rd_data` is 0.
- R2: When `cap_count` and `cap_status` are asserted in the same cycle, the result is the same as capturing count and status in two back-to-back cycles with the same input values.
- R3: A `cap_count` that arrives while a captured count is still unread is dropped, and the held count keeps its first value.
- R4: A `cap_status` that arrives while a captured status byte is still unread is dropped, and the held status keeps its first value.
- R5: When a status byte is held, the next read returns it, even if a count is also held and whichever of the two was captured first.
- R6: In low-only mode (`mode_sel` 2'b01) a held count is read out in one read that returns bits 7:0. In high-only mode (`mode_sel` 2'b10) it is read out in one read that returns bits 15:8.
- R7: In two-byte mode (`mode_sel` 2'b11) a held count takes two reads, bits 7:0 first and bits 15:8 second. It stays held between the two reads.
- R8: When nothing is held, a read returns a byte of the live count. In two-byte mode the byte pointer alternates low/high on every count read, and each byte is sampled in the cycle of its own read.
- R9: A mode write with a `mode_sel` value other than 2'b00 sets the new mode and clears the held status, the held count and the byte pointer. A mode write with 2'b00 has no effect.
- R10: `rd_data` changes only at the clock edge that samples an accepted read, and it holds its value otherwise.
- R11: Order of same-cycle events: an accepted mode write overrides a read and any capture in that cycle (the read is ignored). A read is processed before a capture in the same cycle, so a capture can refill a slot that the read has just emptied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| live_count | input | 16 | Free-running count from the counting engine |
| status_in | input | 8 | Current status byte of the channel |
| mode_wr | input | 1 | Access-mode write strobe |
| mode_sel | input | 2 | Access mode: 01 low only, 10 high only, 11 low then high, 00 ignored |
| cap_count | input | 1 | Capture the live count |
| cap_status | input | 1 | Capture the status byte |
| rd | input | 1 | Read strobe |
| rd_data | output | 8 | Byte returned by the last accepted read |

## Verification
Directed sequences drive capture orders in each access mode: count before status, status before count, and both together. Comparing these separates a design that returns status first from one that returns bytes in arrival order. Repeated captures are given changed live and status inputs, so a design that overwrites the held value returns a different byte from one that drops the repeat. Reads of the live count in two-byte mode change the count between the low and high reads, which shows whether each byte is sampled at its own read. A long run of seeded random strobes then overlaps reads, captures and mode writes in the same cycle. It compares every cycle's `rd_data` with a bench model that applies the mode-write, read-then-capture ordering.

// File: rtl/tmr_rb_pkg.sv
package tmr_rb_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;

  typedef enum logic [1:0] {
    ACC_NONE = 2'b00,
    ACC_LO   = 2'b01,
    ACC_HI   = 2'b10,
    ACC_WORD = 2'b11
  } acc_mode_t;

  // Byte of a 16-bit count that a read returns in a given mode and pointer state
  function automatic logic [BYTE_W-1:0] pick_byte(logic [CNT_W-1:0] v, acc_mode_t m,
                                                  logic hi_next);
    logic use_hi;
    use_hi = (m == ACC_HI) || ((m == ACC_WORD) && hi_next);
    return use_hi ? v[CNT_W-1:BYTE_W] : v[BYTE_W-1:0];
  endfunction

  // True when a count read in this state consumes the last byte of the count
  function automatic logic last_byte(acc_mode_t m, logic hi_next);
    return (m != ACC_WORD) || hi_next;
  endfunction
endpackage

// File: rtl/tmr_rb_hold.sv
module tmr_rb_hold #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         pop,
  input  logic         cap,
  input  logic [W-1:0] d_in,
  output logic         held,
  output logic [W-1:0] q
);
  logic held_after_pop;
  logic take;

  assign held_after_pop = held & ~pop;
  assign take           = cap & ~held_after_pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held <= 1'b0;
      q    <= '0;
    end else if (clr) begin
      held <= 1'b0;
    end else begin
      held <= held_after_pop | take;
      if (take) q <= d_in;
    end
  end

  // R3 for the count slot and R4 for the status slot: a repeat capture is dropped
  assert_drop_repeat_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cap && held && !pop && !clr) |=> (held && $stable(q)));

  assert_clear_on_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !held);
endmodule

// File: rtl/tmr_rb_read_seq.sv
module tmr_rb_read_seq
  import tmr_rb_pkg::*;
#(
  parameter int BW = BYTE_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_wr,
  input  logic [1:0]    mode_sel,
  input  logic          rd,
  input  logic          st_held,
  input  logic [BW-1:0] st_q,
  input  logic          cnt_held,
  input  logic [CW-1:0] cnt_q,
  input  logic [CW-1:0] live_count,
  output logic          mode_load,
  output logic          st_pop,
  output logic          cnt_pop,
  output logic          cnt_read,
  output acc_mode_t     mode_q,
  output logic          ptr_hi,
  output logic [BW-1:0] rd_data
);
  logic          rd_go;
  logic [BW-1:0] byte_out;

  assign mode_load = mode_wr && (mode_sel != ACC_NONE);
  assign rd_go     = rd && !mode_load;
  assign st_pop    = rd_go && st_held;
  assign cnt_read  = rd_go && !st_held;
  assign cnt_pop   = cnt_read && cnt_held && last_byte(mode_q, ptr_hi);
  assign byte_out  = st_held ? st_q
                             : pick_byte(cnt_held ? cnt_q : live_count, mode_q, ptr_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= ACC_WORD;
      ptr_hi  <= 1'b0;
      rd_data <= '0;
    end else begin
      if (mode_load) begin
        mode_q <= acc_mode_t'(mode_sel);
        ptr_hi <= 1'b0;
      end else if (cnt_read && (mode_q == ACC_WORD)) begin
        ptr_hi <= ~ptr_hi;
      end
      if (rd_go) rd_data <= byte_out;
    end
  end

  assert_status_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !mode_load && st_held) |=> (rd_data == $past(st_q)));

  assert_ptr_cleared_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mode_load |=> !ptr_hi);

  assert_data_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_go |=> $stable(rd_data));
endmodule

// File: rtl/tmr_rb_top.sv
module tmr_rb_top
  import tmr_rb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  live_count,
  input  logic [BYTE_W-1:0] status_in,
  input  logic              mode_wr,
  input  logic [1:0]        mode_sel,
  input  logic              cap_count,
  input  logic              cap_status,
  input  logic              rd,
  output logic [BYTE_W-1:0] rd_data
);
  logic              mode_load;
  logic              st_pop;
  logic              cnt_pop;
  logic              cnt_read;
  logic              st_held;
  logic              cnt_held;
  logic [BYTE_W-1:0] st_q;
  logic [CNT_W-1:0]  cnt_q;
  acc_mode_t         mode_q;
  logic              ptr_hi;

  tmr_rb_hold #(.W(BYTE_W)) u_status (
    .clk(clk), .rst_n(rst_n), .clr(mode_load), .pop(st_pop), .cap(cap_status),
    .d_in(status_in), .held(st_held), .q(st_q)
  );

  tmr_rb_hold #(.W(CNT_W)) u_count (
    .clk(clk), .rst_n(rst_n), .clr(mode_load), .pop(cnt_pop), .cap(cap_count),
    .d_in(live_count), .held(cnt_held), .q(cnt_q)
  );

  tmr_rb_read_seq #(.BW(BYTE_W), .CW(CNT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_sel(mode_sel), .rd(rd),
    .st_held(st_held), .st_q(st_q), .cnt_held(cnt_held), .cnt_q(cnt_q),
    .live_count(live_count), .mode_load(mode_load), .st_pop(st_pop),
    .cnt_pop(cnt_pop), .cnt_read(cnt_read), .mode_q(mode_q), .ptr_hi(ptr_hi),
    .rd_data(rd_data)
  );

  assert_single_read_frees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_read && cnt_held && (mode_q != ACC_WORD) && !cap_count) |=> !cnt_held);

  assert_word_low_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_read && cnt_held && (mode_q == ACC_WORD) && !ptr_hi) |=> (cnt_held && ptr_hi));

  assert_both_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_count && cap_status && !cnt_held && !st_held && !mode_load)
      |=> (cnt_held && st_held && (cnt_q == $past(live_count)) && (st_q == $past(status_in))));
endmodule

// File: tb/tmr_rb_top_bench.sv
`timescale 1ns/1ps
module tmr_rb_top_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] live_count = '0;
  logic [7:0]  status_in = '0;
  logic        mode_wr = 1'b0;
  logic [1:0]  mode_sel = 2'b00;
  logic        cap_count = 1'b0;
  logic        cap_status = 1'b0;
  logic        rd = 1'b0;
  logic [7:0]  rd_data;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // bench model state
  bit [1:0]  m_mode = 2'b11;
  bit        m_ptr = 1'b0;
  bit        m_sth = 1'b0;
  bit        m_ch = 1'b0;
  bit [7:0]  m_stq = '0;
  bit [15:0] m_cq = '0;
  bit [7:0]  m_rd = '0;

  always #2 clk = ~clk;

  tmr_rb_top u_tmr_rb_top (
    .clk(clk), .rst_n(rst_n), .live_count(live_count), .status_in(status_in),
    .mode_wr(mode_wr), .mode_sel(mode_sel), .cap_count(cap_count),
    .cap_status(cap_status), .rd(rd), .rd_data(rd_data)
  );

  function automatic bit [7:0] sel_byte(bit [15:0] v, bit [1:0] mode, bit hi);
    bit [3:0] sh;
    sh = (mode == 2'b10 || (mode == 2'b11 && hi)) ? 4'd8 : 4'd0;
    return 8'(v >> sh);
  endfunction

  task automatic check(string tag, logic [7:0] got, logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: rd_data=%h expected=%h at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic model(bit mw, bit [1:0] ms, bit cc, bit cs, bit r,
                       bit [15:0] lv, bit [7:0] sv);
    bit was_hi;
    if (mw && ms != 2'b00) begin
      m_mode = ms; m_ptr = 0; m_sth = 0; m_ch = 0;
      return;
    end
    if (r) begin
      if (m_sth) begin
        m_rd = m_stq; m_sth = 0;
      end else begin
        was_hi = m_ptr;
        m_rd = sel_byte(m_ch ? m_cq : lv, m_mode, m_ptr);
        if (m_mode == 2'b11) m_ptr = ~m_ptr;
        if (m_ch && (m_mode != 2'b11 || was_hi)) m_ch = 0;
      end
    end
    if (cc && !m_ch) begin m_cq = lv; m_ch = 1; end
    if (cs && !m_sth) begin m_stq = sv; m_sth = 1; end
  endtask

  // drive one cycle's inputs, apply to model, compare rd_data after the edge
  task automatic step(bit mw, bit [1:0] ms, bit cc, bit cs, bit r,
                      bit [15:0] lv, bit [7:0] sv, string tag);
    mode_wr = mw; mode_sel = ms; cap_count = cc; cap_status = cs; rd = r;
    live_count = lv; status_in = sv;
    @(posedge clk);
    model(mw, ms, cc, cs, r, lv, sv);
    @(negedge clk);
    check(tag, rd_data, m_rd);
    mode_wr = 0; cap_count = 0; cap_status = 0; rd = 0;
  endtask

  task automatic expect_byte(string tag, logic [7:0] exp);
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    bit [15:0] lv;
    bit [7:0]  sv;
    bit [1:0]  ms;
    process::self().srandom(32'h5EED_0042);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    expect_byte("R1 reset rd_data", 8'h00);

    // R1/R8: default two-byte, live count low then high sampled per read
    step(0, 0, 0, 0, 1, 16'hA55A, 8'h00, "R1 first read low");
    expect_byte("R1 literal low", 8'h5A);
    step(0, 0, 0, 0, 1, 16'h1234, 8'h00, "R8 live high own sample");
    expect_byte("R8 literal high", 8'h12);
    step(0, 0, 0, 0, 0, 16'h9999, 8'h00, "R10 idle hold");

    // R6 low-only, R3 repeat dropped
    step(1, 2'b01, 0, 0, 0, 16'h0000, 8'h00, "R9 set low mode");
    step(0, 0, 1, 0, 0, 16'hBEEF, 8'h00, "R6 capture");
    step(0, 0, 1, 0, 0, 16'h0000, 8'h00, "R3 repeat capture");
    step(0, 0, 0, 0, 1, 16'h7777, 8'h00, "R3 held value kept");
    expect_byte("R6 literal low", 8'hEF);
    step(0, 0, 0, 0, 1, 16'h4321, 8'h00, "R8 live after held");

    // R4, R5, R6 high-only
    step(1, 2'b10, 0, 0, 0, 16'h0, 8'h00, "R9 set high mode");
    step(0, 0, 0, 1, 0, 16'h0, 8'h5C, "R4 status capture");
    step(0, 0, 0, 1, 0, 16'h0, 8'h11, "R4 repeat status");
    step(0, 0, 1, 0, 0, 16'hCAFE, 8'h22, "R5 count after status");
    step(0, 0, 0, 0, 1, 16'h0, 8'h33, "R5 status first");
    expect_byte("R4 literal status", 8'h5C);
    step(0, 0, 0, 0, 1, 16'h0, 8'h33, "R6 high byte");
    expect_byte("R6 literal high", 8'hCA);
    step(0, 0, 0, 0, 1, 16'hAB00, 8'h33, "R8 live high only");

    // R5 count captured first, R7 two-byte
    step(1, 2'b11, 0, 0, 0, 16'h0, 8'h00, "R9 set word mode");
    step(0, 0, 1, 0, 0, 16'h1357, 8'h00, "R7 capture count");
    step(0, 0, 0, 1, 0, 16'hFFFF, 8'h81, "R5 status second");
    step(0, 0, 0, 0, 1, 16'hFFFF, 8'h00, "R5 status out first");
    expect_byte("R5 literal", 8'h81);
    step(0, 0, 0, 0, 1, 16'hFFFF, 8'h00, "R7 low byte");
    expect_byte("R7 literal low", 8'h57);
    step(0, 0, 0, 0, 1, 16'hFFFF, 8'h00, "R7 high byte");
    expect_byte("R7 literal high", 8'h13);
    step(0, 0, 0, 0, 1, 16'h2468, 8'h00, "R8 live low");

    // R2 simultaneous capture
    step(0, 0, 0, 0, 1, 16'h0, 8'h00, "R8 realign pointer");
    step(0, 0, 1, 1, 0, 16'h6A6B, 8'h3C, "R2 both at once");
    step(0, 0, 1, 1, 0, 16'h0000, 8'h00, "R2 repeat both");
    step(0, 0, 0, 0, 1, 16'h0, 8'h00, "R2 status");
    expect_byte("R2 literal status", 8'h3C);
    step(0, 0, 0, 0, 1, 16'h0, 8'h00, "R2 count low");
    expect_byte("R2 literal low", 8'h6B);
    step(0, 0, 0, 0, 1, 16'h0, 8'h00, "R2 count high");

    // R9 mode write clears; 00 ignored
    step(0, 0, 1, 1, 0, 16'h5555, 8'h66, "R9 hold both");
    step(1, 2'b11, 0, 0, 0, 16'h0, 8'h00, "R9 mode clears");
    step(0, 0, 0, 0, 1, 16'hC3D4, 8'h00, "R9 live after clear");
    expect_byte("R9 literal", 8'hD4);
    step(0, 0, 0, 0, 1, 16'h0, 8'h00, "R9 finish pair");
    step(0, 0, 1, 0, 0, 16'h8E8F, 8'h00, "R9 capture before 00");
    step(1, 2'b00, 0, 0, 0, 16'h0, 8'h00, "R9 code 00 ignored");
    step(0, 0, 0, 0, 1, 16'h0, 8'h00, "R9 held survives 00");
    expect_byte("R9 literal 00", 8'h8F);

    // R11 ordering
    step(1, 2'b01, 0, 0, 1, 16'hEEEE, 8'h00, "R11 mode beats read");
    step(0, 0, 1, 0, 0, 16'h0102, 8'h00, "R11 capture");
    step(0, 0, 1, 0, 1, 16'h0304, 8'h00, "R11 read then recapture");
    expect_byte("R11 literal", 8'h02);
    step(0, 0, 0, 0, 1, 16'h0, 8'h00, "R11 recaptured value");
    expect_byte("R11 literal 2", 8'h04);

    // seeded random mix
    for (int i = 0; i < 4000; i++) begin
      lv = 16'($urandom);
      sv = 8'($urandom);
      ms = 2'($urandom);
      step(($urandom % 16) == 0, ms, ($urandom % 4) == 0, ($urandom % 5) == 0,
           ($urandom % 2) == 0, lv, sv, "R8 random mix");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule